// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block produces the memory address for a single-register load or store. It also produces the new base value to be written back into the register file. It takes a 32-bit base register value and an offset. The offset is either an unsigned 12-bit byte immediate, or a 32-bit index register value shifted left by 0 to 31 places. A direction bit selects whether the offset is added to the base or subtracted from it.

A two-bit indexing control chooses how the sum is used:
- **Pre-indexed:** the access goes to base±offset. That same sum can optionally be written back to the base register.
- **Post-indexed:** the access goes to the unmodified base, and the base register is always updated to base±offset.

The block is purely combinational. Its outputs settle in the same cycle the operands are presented. It does not read or write the register file, issue memory requests, or check alignment.

Top module: `ls_addr_gen`

## Requirements
- R1: When `off_is_reg` is 0, the offset is `imm_off` zero-extended to 32 bits (a byte count).
- R2: When `off_is_reg` is 1, the offset is `idx_val` shifted left by `idx_shamt` (0 to 31). Bits shifted beyond bit 31 are discarded.
- R3: When `dir_up` is 1, the offset is added to `base_val`. When it is 0, the offset is subtracted. The result wraps modulo 2^32.
- R4: When `post_idx` is 0 (pre-indexed), `acc_addr` equals the wrapped base±offset sum.
- R5: When `post_idx` is 1 (post-indexed), `acc_addr` equals `base_val` unchanged.
- R6: In every mode, `wb_val` equals the wrapped base±offset sum.
- R7: `wb_en` is 1 whenever `post_idx` is 1. Otherwise it equals `wb_req`.
- R8: With a zero offset (immediate 0, or a zero shifted index), the pre-indexed address equals `base_val`. This is the plain base-register mode.
- R9: All outputs reflect the current inputs in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_val | input | 32 | Base register value |
| off_is_reg | input | 1 | 1: shifted index offset, 0: immediate offset |
| imm_off | input | 12 | Unsigned immediate byte offset |
| idx_val | input | 32 | Index register value |
| idx_shamt | input | 5 | Left shift applied to the index |
| dir_up | input | 1 | 1: add offset, 0: subtract offset |
| post_idx | input | 1 | 1: post-indexed, 0: pre-indexed |
| wb_req | input | 1 | Writeback request for pre-indexed mode |
| acc_addr | output | 32 | Effective access address |
| wb_val | output | 32 | Updated base value |
| wb_en | output | 1 | Base writeback enable |

## Verification
Address selection and base update both happen in the same cycle. In post-indexed mode they diverge: the address must keep the old base while the writeback value carries the new sum.

The bench drives post-indexed and pre-indexed-with-writeback vectors back to back. It covers both directions and both offset sources, including sums that wrap past zero and past 2^32. On every clock, a behavioural model computes the address, writeback value and enable separately, and each is compared against the outputs. A mismatch in one output cannot be masked by agreement in another.

// File: rtl/ls_agu_pkg.sv
// Package: shared widths and the offset-source encoding for the address generator.
// Assumes a byte-addressed 32-bit datapath.
package ls_agu_pkg;
    localparam int unsigned AGU_DATA_W = 32;
    localparam int unsigned AGU_IMM_W  = 12;

    typedef enum logic {
        OFF_SRC_IMM = 1'b0,
        OFF_SRC_REG = 1'b1
    } off_src_e;
endpackage

// File: rtl/ls_off_sel.sv
// Module: ls_off_sel
// Forms the byte offset: either a zero-extended immediate magnitude or a
// left-shifted index value. Assumes SHAMT_W bits cover 0..DATA_W-1.
module ls_off_sel #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned IMM_W   = 12,
    parameter int unsigned SHAMT_W = $clog2(DATA_W)
) (
    input  ls_agu_pkg::off_src_e src,
    input  logic [IMM_W-1:0]     imm,
    input  logic [DATA_W-1:0]    idx,
    input  logic [SHAMT_W-1:0]   shamt,
    output logic [DATA_W-1:0]    offset
);
    localparam int unsigned PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] idx_shl;

    // Zero-extend the immediate magnitude to the datapath width.
    always_comb imm_ext = {{PAD_W{1'b0}}, imm};

    // Shift the index; bits beyond the top are dropped.
    always_comb idx_shl = idx << shamt;

    // Choose the offset source.
    always_comb begin
        if (src == ls_agu_pkg::OFF_SRC_REG) offset = idx_shl;
        else                                offset = imm_ext;
    end
endmodule

// File: rtl/ls_addsub.sv
// Module: ls_addsub
// Adds or subtracts the offset from the base, wrapping at DATA_W bits.
// Subtraction uses the inverted operand with a carry-in of one.
module ls_addsub #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] offset,
    input  logic              up,
    output logic [DATA_W-1:0] sum
);
    logic [DATA_W-1:0] opnd;

    // Invert the offset when subtracting.
    always_comb opnd = up ? offset : ~offset;

    // Single adder with carry-in selecting subtract.
    always_comb sum = base + opnd + {{(DATA_W-1){1'b0}}, ~up};
endmodule

// File: rtl/ls_idx_mux.sv
// Module: ls_idx_mux
// Applies the indexing mode: picks the access address and the writeback
// enable. Assumes the sum is already formed upstream.
module ls_idx_mux #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] sum,
    input  logic              post,
    input  logic              wb_req,
    output logic [DATA_W-1:0] addr,
    output logic [DATA_W-1:0] wb_data,
    output logic              wb_en
);
    // Post-indexed accesses use the old base; pre-indexed use the sum.
    always_comb addr = post ? base : sum;

    // The updated base is always the sum.
    always_comb wb_data = sum;

    // Post-indexing forces writeback; pre-indexing follows the request.
    always_comb wb_en = post | wb_req;
endmodule

// File: rtl/ls_addr_gen.sv
// Module: ls_addr_gen (top)
// Combinational effective-address and base-update generator for single
// register loads and stores. No clock: outputs follow inputs in-cycle.
// Assumes register-file access and alignment checks live elsewhere.
module ls_addr_gen #(
    parameter int unsigned DATA_W  = ls_agu_pkg::AGU_DATA_W,
    parameter int unsigned IMM_W   = ls_agu_pkg::AGU_IMM_W,
    parameter int unsigned SHAMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  base_val,
    input  logic               off_is_reg,
    input  logic [IMM_W-1:0]   imm_off,
    input  logic [DATA_W-1:0]  idx_val,
    input  logic [SHAMT_W-1:0] idx_shamt,
    input  logic               dir_up,
    input  logic               post_idx,
    input  logic               wb_req,
    output logic [DATA_W-1:0]  acc_addr,
    output logic [DATA_W-1:0]  wb_val,
    output logic               wb_en
);
    ls_agu_pkg::off_src_e src;
    logic [DATA_W-1:0]    offset;
    logic [DATA_W-1:0]    sum;

    // Map the raw select bit onto the offset-source type.
    always_comb src = ls_agu_pkg::off_src_e'(off_is_reg);

    ls_off_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W)) u_off (
        .src(src), .imm(imm_off), .idx(idx_val), .shamt(idx_shamt), .offset(offset)
    );

    ls_addsub #(.DATA_W(DATA_W)) u_add (
        .base(base_val), .offset(offset), .up(dir_up), .sum(sum)
    );

    ls_idx_mux #(.DATA_W(DATA_W)) u_mux (
        .base(base_val), .sum(sum), .post(post_idx), .wb_req(wb_req),
        .addr(acc_addr), .wb_data(wb_val), .wb_en(wb_en)
    );

    // Cross-check the outputs of the mode mux against the operands.
    always_comb begin
        // R5
        post_addr_chk: assert (!post_idx || acc_addr == base_val);
        // R4
        pre_addr_chk: assert (post_idx || acc_addr == wb_val);
        // R7
        post_wb_chk: assert (!post_idx || wb_en);
        // R8
        zero_off_chk: assert (off_is_reg || imm_off != '0 || wb_val == base_val);
        // R3
        up_zero_chk: assert (!dir_up || offset != '0 || sum == base_val);
    end
endmodule

// File: tb/ls_addr_gen_test.sv
module ls_addr_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_en = 1'b0;
    logic [31:0] base_val = '0;
    logic        off_is_reg = 1'b0;
    logic [11:0] imm_off = '0;
    logic [31:0] idx_val = '0;
    logic [4:0]  idx_shamt = '0;
    logic        dir_up = 1'b0;
    logic        post_idx = 1'b0;
    logic        wb_req = 1'b0;
    logic [31:0] acc_addr;
    logic [31:0] wb_val;
    logic        wb_en;
    string       tag = "reset";

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    ls_addr_gen uut (
        .base_val(base_val), .off_is_reg(off_is_reg), .imm_off(imm_off),
        .idx_val(idx_val), .idx_shamt(idx_shamt), .dir_up(dir_up),
        .post_idx(post_idx), .wb_req(wb_req),
        .acc_addr(acc_addr), .wb_val(wb_val), .wb_en(wb_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural model: 64-bit integer arithmetic masked to 32 bits.
    function automatic longint model_sum();
        longint off;
        longint s;
        if (off_is_reg) off = (longint'(idx_val) << idx_shamt) & 64'hFFFF_FFFF; // R2
        else            off = longint'(imm_off);                                 // R1
        if (dir_up) s = longint'(base_val) + off;                                // R3
        else        s = longint'(base_val) - off;
        return s & 64'hFFFF_FFFF;
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%h expected=%h", req, tag, act, exp);
        end
    endtask

    // Compare every output against the model on each clock (R9: same cycle).
    always @(posedge clk) begin
        cyc++;
        if (chk_en) begin
            longint s;
            s = model_sum();
            check(post_idx ? "R5 addr" : "R4 addr", longint'(acc_addr),
                  post_idx ? longint'(base_val) : s);
            check("R6 wbval", longint'(wb_val), s);
            check("R7 wben", longint'(wb_en), longint'(post_idx | wb_req));
        end
        if (cyc > WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic drive(string t, logic [31:0] b, logic r, logic [11:0] im,
                         logic [31:0] ix, logic [4:0] sh, logic up, logic post, logic wr);
        @(negedge clk);
        tag = t; base_val = b; off_is_reg = r; imm_off = im; idx_val = ix;
        idx_shamt = sh; dir_up = up; post_idx = post; wb_req = wr;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk_en = 1'b1;                                               // reset state: all zero
        @(posedge clk);
        drive("R8 plain base",   32'h200, 0, 12'd0, 0, 0, 1, 0, 0);
        drive("R1 R4 +12",       32'h200, 0, 12'd12, 0, 0, 1, 0, 0);
        drive("R3 -12",          32'h200, 0, 12'd12, 0, 0, 0, 0, 0);
        drive("R4 pre wb",       32'h200, 0, 12'd12, 0, 0, 1, 0, 1);
        drive("R5 post",         32'h200, 0, 12'd12, 0, 0, 1, 1, 0);
        drive("R5 post down",    32'h200, 0, 12'd12, 0, 0, 0, 1, 1);
        drive("R2 idx 3<<2",     32'h200, 1, 12'hFFF, 32'd3, 5'd2, 1, 0, 0);
        drive("R2 post idx",     32'h200, 1, 12'd0, 32'd3, 5'd2, 1, 1, 0);
        drive("R2 shamt31",      32'h10, 1, 12'd0, 32'h3, 5'd31, 1, 0, 1);
        drive("R2 drop bits",    32'h0, 1, 12'd0, 32'hFFFF_FFFF, 5'd8, 1, 0, 0);
        drive("R8 zero idx",     32'h1234, 1, 12'd5, 32'h0, 5'd4, 0, 0, 1);
        drive("R3 wrap up",      32'hFFFF_FFFC, 0, 12'd8, 0, 0, 1, 0, 1);
        drive("R3 wrap down",    32'h4, 0, 12'hFFF, 0, 0, 0, 1, 0);
        drive("R1 imm max",      32'h8000_0000, 0, 12'hFFF, 32'hDEAD, 5'd1, 1, 0, 0);
        for (int i = 0; i < 200; i++) begin
            drive("mixed", $urandom, 1'($urandom), 12'($urandom), $urandom,
                  5'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end
        @(negedge clk);
        chk_en = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule